// File: doc/BRIEF.md
# Two-Stage Oversampling Baud Tick Generator

This block derives two timing strobes for an asynchronous serial port from a single module clock. A first divider counts module clock cycles modulo a 13-bit divisor and emits a receive sampling strobe. A second divider counts those sampling strobes modulo (ratio + 1) and emits a transmit bit strobe. The ratio comes from a 5-bit oversampling field. The receive strobe therefore runs at (ratio + 1) times the bit rate, and the transmit strobe runs at the bit rate.

Both rates are plain integer quotients of the module clock, and no correction is made for rounding. A divisor of zero stops the whole generator. A change of the divisor or of the oversampling field restarts both dividers from the beginning, so the first strobe under the new setting arrives one full new period later. Turning the enable on also restarts them.

Top module: `baud_tick_gen`

## Requirements
- R1: While rst_ni is low, and after its release until the first period of an enabled, nonzero setting has elapsed, rx_tick_o and tx_tick_o are both 0.
- R2: With en_i high and a divisor D held constant in 1..8191, rx_tick_o is high in the cycle D clock edges after the restart edge and again every D cycles after that. With D = 1 it is high on every cycle.
- R3: tx_tick_o is high only together with rx_tick_o. Counted from a restart, it accompanies every (S+1)-th receive strobe, where S is the oversampling field, so its period is D×(S+1) cycles.
- R4: A divisor of 0 produces no strobe on either output, whatever the state of en_i and the oversampling field.
- R5: While en_i is low both outputs stay 0. A low-to-high transition of en_i is a restart edge.
- R6: A clock edge at which divisor_i differs from its value at the previous edge is a restart edge. Both counters clear, both outputs are 0 in the following cycle, and the next strobes follow R2 and R3 measured from that edge.
- R7: A clock edge at which osr_i differs from its value at the previous edge is a restart edge, with the same effect as in R6.
- R8: For any divisor other than 1, rx_tick_o is never high on two consecutive cycles. Each strobe is one module clock wide.
- R9: The oversampling field is 5 bits wide and every value from 0 to 31 gives a transmit period of D×(S+1). S = 0 makes the two strobes identical.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Generator enable; a rising edge restarts both dividers |
| divisor_i | input | 13 | First-stage modulo divisor; 0 switches the generator off |
| osr_i | input | 5 | Oversampling field S; the second stage divides by S+1 |
| rx_tick_o | output | 1 | Receive sampling strobe, one cycle wide, period D |
| tx_tick_o | output | 1 | Transmit bit strobe, one cycle wide, period D×(S+1) |

## Verification
A first-stage count that skips or repeats a value shows up as a receive strobe one or more cycles early or late. That error is visible at the next strobe, at most D cycles after the fault. A wrong oversampling count moves the transmit strobe off its place among the receive strobes, which is visible within D×(S+1) cycles. A restart that does not take effect keeps the old phase, so the first strobe after a setting change arrives at the wrong cycle. A divisor of zero or a low enable that leaks through shows up as a strobe where none is expected.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned DIV_W_DEF = 13;
  localparam int unsigned OSR_W_DEF = 5;

  typedef struct packed {
    logic load;  // setting changed or enable rose this edge
    logic run;   // counters advance this edge
  } gen_ctl_t;
endpackage

// File: rtl/baud_cfg_track.sv
module baud_cfg_track
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W = DIV_W_DEF,
  parameter int unsigned OSR_W = OSR_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [OSR_W-1:0] osr_i,
  output gen_ctl_t         ctl_o
);
  logic [DIV_W-1:0] div_q;
  logic [OSR_W-1:0] osr_q;
  logic             en_q;
  logic             chg;

  always_comb begin
    chg       = (div_i != div_q) || (osr_i != osr_q) || (en_i && !en_q);
    ctl_o.load = chg;
    ctl_o.run  = en_i && (div_i != '0) && !chg;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      osr_q <= '0;
      en_q  <= 1'b0;
    end else begin
      div_q <= div_i;
      osr_q <= osr_i;
      en_q  <= en_i;
    end
  end
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W = DIV_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  gen_ctl_t         ctl_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             wrap_o,
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0] cnt_q;

  assign wrap_o = ctl_i.run && (cnt_q == (div_i - ONE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (!ctl_i.run) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (wrap_o) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + ONE;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/baud_osr_stage.sv
module baud_osr_stage
  import baud_pkg::*;
#(
  parameter int unsigned OSR_W = OSR_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  gen_ctl_t         ctl_i,
  input  logic             wrap_i,
  input  logic [OSR_W-1:0] osr_i,
  output logic             tick_o
);
  localparam logic [OSR_W-1:0] ONE = {{(OSR_W-1){1'b0}}, 1'b1};

  logic [OSR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (!ctl_i.run) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (wrap_i) begin
      if (cnt_q == osr_i) begin
        cnt_q  <= '0;
        tick_o <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + ONE;
        tick_o <= 1'b0;
      end
    end else begin
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W = DIV_W_DEF,
  parameter int unsigned OSR_W = OSR_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] divisor_i,
  input  logic [OSR_W-1:0] osr_i,
  output logic             rx_tick_o,
  output logic             tx_tick_o
);
  gen_ctl_t ctl;
  logic     wrap;

  baud_cfg_track #(.DIV_W(DIV_W), .OSR_W(OSR_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .div_i  (divisor_i),
    .osr_i  (osr_i),
    .ctl_o  (ctl)
  );

  baud_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctl_i  (ctl),
    .div_i  (divisor_i),
    .wrap_o (wrap),
    .tick_o (rx_tick_o)
  );

  baud_osr_stage #(.OSR_W(OSR_W)) u_osr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctl_i  (ctl),
    .wrap_i (wrap),
    .osr_i  (osr_i),
    .tick_o (tx_tick_o)
  );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int unsigned DIV_W = 13,
  parameter int unsigned OSR_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [DIV_W-1:0] divisor_i,
  input logic [OSR_W-1:0] osr_i,
  input logic             rx_tick_o,
  input logic             tx_tick_o
);
  localparam int unsigned TX_W = DIV_W + OSR_W + 1;

  logic [DIV_W-1:0] div_p;
  logic [OSR_W-1:0] osr_p;
  logic             en_p;
  logic             chg;
  logic [DIV_W:0]   rx_gap;
  logic [TX_W-1:0]  tx_gap;
  logic             rx_clean, tx_clean;

  assign chg = (divisor_i != div_p) || (osr_i != osr_p) || (en_i != en_p);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_p <= '0; osr_p <= '0; en_p <= 1'b0;
      rx_gap <= '0; tx_gap <= '0; rx_clean <= 1'b0; tx_clean <= 1'b0;
    end else begin
      div_p <= divisor_i; osr_p <= osr_i; en_p <= en_i;
      // R2: receive strobe spacing equals the divisor under a steady setting
      if (rx_tick_o && rx_clean && !chg)
        assert_rx_period_R2: assert (rx_gap == {1'b0, divisor_i})
          else $error("rx period %0d, divisor %0d", rx_gap, divisor_i);
      // R3: transmit strobe spacing equals divisor*(osr+1)
      if (tx_tick_o && tx_clean && !chg)
        assert_tx_period_R3: assert (tx_gap == TX_W'(divisor_i) * (TX_W'(osr_i) + 1'b1))
          else $error("tx period %0d", tx_gap);
      rx_gap   <= rx_tick_o ? 1 : rx_gap + 1'b1;
      tx_gap   <= tx_tick_o ? 1 : tx_gap + 1'b1;
      rx_clean <= chg ? 1'b0 : (rx_tick_o ? 1'b1 : rx_clean);
      tx_clean <= chg ? 1'b0 : (tx_tick_o ? 1'b1 : tx_clean);
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!rx_tick_o && !tx_tick_o));

  assert_tx_with_rx_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_tick_o |-> rx_tick_o);

  assert_zero_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (divisor_i == '0) |=> (!rx_tick_o && !tx_tick_o));

  assert_disabled_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!rx_tick_o && !tx_tick_o));

  assert_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (divisor_i != div_p) |=> !rx_tick_o);

  assert_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osr_i != osr_p) |=> (!rx_tick_o && !tx_tick_o));

  assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_tick_o && divisor_i != 13'd1) |=> !rx_tick_o);
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.DIV_W(DIV_W), .OSR_W(OSR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .divisor_i (divisor_i),
  .osr_i     (osr_i),
  .rx_tick_o (rx_tick_o),
  .tx_tick_o (tx_tick_o)
);

// File: tb/baud_tick_gen_bench.sv
`timescale 1ns/1ps
module baud_tick_gen_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [12:0] divisor_i = '0;
  logic [4:0]  osr_i = '0;
  logic        rx_tick_o, tx_tick_o;

  int    cyc = 0;
  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  int    rx_q[$];
  int    tx_q[$];
  bit    finished = 1'b0;

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  baud_tick_gen u_baud_tick_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .divisor_i (divisor_i),
    .osr_i     (osr_i),
    .rx_tick_o (rx_tick_o),
    .tx_tick_o (tx_tick_o)
  );

  // Driver: applies a setting, schedules the expected strobe cycles
  task automatic apply(input int d, input int s, input bit e, input int n, input string req);
    int p;
    @(posedge clk_i); #1;
    divisor_i = 13'(d);
    osr_i     = 5'(s);
    en_i      = e;
    cur_req   = req;
    p = cyc;
    if (e && d != 0) begin
      for (int t = p + 1 + d; t <= p + n + 1; t += d) rx_q.push_back(t);
      for (int t = p + 1 + d * (s + 1); t <= p + n + 1; t += d * (s + 1)) tx_q.push_back(t);
    end
    repeat (n) @(posedge clk_i);
  endtask

  // Monitor: compares outputs against the queued schedule every cycle
  initial begin
    forever begin
      bit exp_rx, exp_tx;
      @(negedge clk_i);
      if (finished) break;
      exp_rx = (rx_q.size() > 0) && (rx_q[0] == cyc);
      exp_tx = (tx_q.size() > 0) && (tx_q[0] == cyc);
      if (exp_rx) void'(rx_q.pop_front());
      if (exp_tx) void'(tx_q.pop_front());
      n_chk += 2;
      if (rx_tick_o !== exp_rx) begin
        n_bad++;
        $display("FAIL %s rx_tick cyc %0d: got %b exp %b", cur_req, cyc, rx_tick_o, exp_rx);
      end
      if (tx_tick_o !== exp_tx) begin
        n_bad++;
        $display("FAIL %s tx_tick cyc %0d: got %b exp %b", cur_req, cyc, tx_tick_o, exp_tx);
      end
    end
  end

  initial begin
    #200000000;
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (4) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    repeat (3) @(posedge clk_i);
    apply(1, 0, 1'b1, 20, "R2");        // every cycle
    apply(2, 3, 1'b1, 60, "R3");
    apply(3, 31, 1'b1, 400, "R9");      // largest ratio
    apply(2, 0, 1'b1, 20, "R9");        // ratio 0: both strobes equal
    apply(0, 2, 1'b1, 50, "R4");        // divisor zero: off
    apply(4, 2, 1'b1, 40, "R2");
    apply(4, 2, 1'b0, 30, "R5");        // disabled
    apply(4, 2, 1'b1, 40, "R5");        // enable rise restarts
    apply(5, 1, 1'b1, 7, "R6");         // interrupted mid-period
    apply(6, 1, 1'b1, 40, "R6");
    apply(6, 4, 1'b1, 9, "R7");
    apply(6, 2, 1'b1, 50, "R7");
    apply(7, 2, 1'b1, 60, "R8");
    apply(8191, 1, 1'b1, 33000, "R2");  // largest divisor
    apply(8191, 1, 1'b0, 10, "R5");
    finished = 1'b1;
    @(negedge clk_i);
    if (rx_q.size() != 0 || tx_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2 pending strobes: got %0d/%0d exp 0/0", rx_q.size(), tx_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule